// File: doc/BRIEF.md
# Port Access Permission Checker

This block decides whether a task may touch an I/O port of byte, word or doubleword width. It takes one request at a time: a port number, an access width, the base address of the task-state area and a flag marking the older 16-bit task-state format. For a current-format task it makes two reads over a simple request/ready memory port. The first read fetches the bitmap offset from the task-state area. The second read fetches the bitmap bits that cover the port. It then reports allowed or denied with a one-cycle completion pulse.

An access of width N covers N consecutive bitmap bits, starting at bit (port mod 8) of the bitmap byte the port falls in. A wide access whose starting bit sits high in that byte runs into the following byte. For that reason the bitmap is always fetched as two bytes. An older-format task is refused at once, and the memory port is never touched for it.

Top module: `port_access_gate`

## Requirements
- R1: After reset, `done` and `mem_req` are low and the unit waits for a request.
- R2: A request with `req_legacy` high makes the unit raise `done` with `allowed` low one cycle after it is accepted, and `mem_req` is never raised for that request.
- R3: For a current-format request, the first memory read uses address `req_base + 66`, wrapping at the address width. The 16 bits returned are taken as the bitmap offset, with the low byte in `mem_rdata[7:0]`.
- R4: The second memory read uses address offset + (`req_port` >> 3), with the offset zero-extended. It returns two bitmap bytes: the byte at that address in bits 7:0 and the following byte in bits 15:8.
- R5: The access mask is built from a base mask selected by `req_width` and then shifted left by `req_port[2:0]`. The base mask is 1 for code 0 (byte), 3 for code 1 (word), and 15 for codes 2 and 3 (doubleword). After the shift the mask may reach into bits 15:8.
- R6: `allowed` is high only when every bitmap bit under the shifted mask is zero.
- R7: `done` is high for exactly one cycle, with `allowed` valid in that same cycle. For a current-format request, `done` rises in the cycle after `mem_ready` is sampled high on the second read.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` does not change.
- R9: `req_valid` is ignored unless the unit is idle. A request raised while a check is in progress changes neither the result nor the addresses read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a check (taken only when idle) |
| req_port | input | PORT_W | I/O port number |
| req_width | input | 2 | Access width code: 0 byte, 1 word, 2 or 3 doubleword |
| req_legacy | input | 1 | Task state uses the older 16-bit format |
| req_base | input | ADDR_W | Task-state area base address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_ready | input | 1 | Read data valid, request complete |
| mem_rdata | input | 16 | Two bytes, little-endian, from `mem_addr` |
| done | output | 1 | One-cycle completion pulse |
| allowed | output | 1 | Access permitted (valid with `done`) |

## Verification
The assertions watch four things on every cycle:
- The request handshake: a pending request holds its address, and the first read address follows the base that was accepted.
- The refusal of older-format tasks without a memory request.
- The single-cycle shape of `done`.
- The rule that `done` only follows a completed read or an older-format acceptance.

The permission result itself is shown only by the bench scenarios. These cover the mask for each width code, shifts that carry the mask into the second bitmap byte, the address of the second read, address wrap, and requests raised while the unit is busy.

// File: rtl/pag_pkg.sv
package pag_pkg;
  // Two bitmap bytes cover any shifted mask of up to 4 + 7 = 11 bits.
  localparam int MAP_W   = 16;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_PTR = 2'd1,
    ST_READ_MAP = 2'd2,
    ST_DONE     = 2'd3
  } pag_state_e;
endpackage

// File: rtl/pag_mask_gen.sv
module pag_mask_gen
  import pag_pkg::*;
(
  input  logic [1:0]         width,
  input  logic [SHIFT_W-1:0] shift,
  output logic [MAP_W-1:0]   mask
);
  localparam int BASE_W = 4;

  logic [BASE_W-1:0] base_mask;

  always_comb begin
    unique case (width)
      2'd0:    base_mask = 4'b0001;
      2'd1:    base_mask = 4'b0011;
      default: base_mask = 4'b1111;
    endcase
  end

  assign mask = {{(MAP_W-BASE_W){1'b0}}, base_mask} << shift;
endmodule

// File: rtl/pag_addr_gen.sv
module pag_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int PTR_W      = 16,
  parameter int PTR_OFFSET = 66
) (
  input  logic              sel_ptr,
  input  logic [ADDR_W-1:0] base,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PORT_W-1:0] port,
  output logic [ADDR_W-1:0] addr
);
  localparam int BYTE_SHIFT = 3;

  logic [ADDR_W-1:0] ptr_addr;
  logic [ADDR_W-1:0] map_addr;

  assign ptr_addr = base + ADDR_W'(PTR_OFFSET);
  assign map_addr = ADDR_W'(ptr) + ADDR_W'(port >> BYTE_SHIFT);
  assign addr     = sel_ptr ? ptr_addr : map_addr;
endmodule

// File: rtl/pag_ctrl.sv
module pag_ctrl
  import pag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_width,
  input  logic              req_legacy,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              mem_ready,
  input  logic [MAP_W-1:0]  mem_rdata,
  input  logic [MAP_W-1:0]  mask,
  output pag_state_e        state,
  output logic [PORT_W-1:0] port_q,
  output logic [1:0]        width_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [MAP_W-1:0]  ptr_q,
  output logic              allowed_q
);
  pag_state_e state_q, state_d;
  logic       accept_en;
  logic       ptr_en;
  logic       res_en;
  logic       res_d;

  always_comb begin
    state_d   = state_q;
    accept_en = 1'b0;
    ptr_en    = 1'b0;
    res_en    = 1'b0;
    res_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept_en = 1'b1;
          if (req_legacy) begin
            res_en  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_READ_PTR;
          end
        end
      end
      ST_READ_PTR: begin
        if (mem_ready) begin
          ptr_en  = 1'b1;
          state_d = ST_READ_MAP;
        end
      end
      ST_READ_MAP: begin
        if (mem_ready) begin
          res_en  = 1'b1;
          res_d   = ((mem_rdata & mask) == '0);
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      width_q <= '0;
      base_q  <= '0;
    end else if (accept_en) begin
      port_q  <= req_port;
      width_q <= req_width;
      base_q  <= req_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      allowed_q <= 1'b0;
    else if (res_en) allowed_q <= res_d;
  end

  assign state = state_q;
endmodule

// File: rtl/port_access_gate.sv
module port_access_gate
  import pag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int PTR_OFFSET = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_width,
  input  logic              req_legacy,
  input  logic [ADDR_W-1:0] req_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [MAP_W-1:0]  mem_rdata,
  output logic              done,
  output logic              allowed
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  pag_state_e        state;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        width_q;
  logic [ADDR_W-1:0] base_q;
  logic [MAP_W-1:0]  ptr_q;
  logic [MAP_W-1:0]  mask;
  logic              allowed_q;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pag_ctrl #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_port   (req_port),
    .req_width  (req_width),
    .req_legacy (req_legacy),
    .req_base   (req_base),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mask       (mask),
    .state      (state),
    .port_q     (port_q),
    .width_q    (width_q),
    .base_q     (base_q),
    .ptr_q      (ptr_q),
    .allowed_q  (allowed_q)
  );

  pag_mask_gen u_mask (
    .width (width_q),
    .shift (port_q[SHIFT_W-1:0]),
    .mask  (mask)
  );

  pag_addr_gen #(
    .ADDR_W     (ADDR_W),
    .PORT_W     (PORT_W),
    .PTR_W      (MAP_W),
    .PTR_OFFSET (PTR_OFFSET)
  ) u_addr (
    .sel_ptr (state == ST_READ_PTR),
    .base    (base_q),
    .ptr     (ptr_q),
    .port    (port_q),
    .addr    (mem_addr)
  );

  assign mem_req = (state == ST_READ_PTR) || (state == ST_READ_MAP);
  assign done    = (state == ST_DONE);
  assign allowed = allowed_q;
endmodule

// File: rtl/pag_checker.sv
module pag_checker
  import pag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PTR_OFFSET = 66
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_legacy,
  input logic [ADDR_W-1:0] req_base,
  input logic [1:0]        state,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              allowed
);
  logic idle;
  assign idle = (state == ST_IDLE);

  p_legacy_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_valid && req_legacy) |=> (done && !allowed && !mem_req));

  p_ptr_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_valid && !req_legacy) |=>
      (mem_req && mem_addr == $past(req_base) + ADDR_W'(PTR_OFFSET)));

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mem_req && mem_ready) || $past(req_valid && req_legacy)));
endmodule

bind port_access_gate pag_checker #(
  .ADDR_W     (ADDR_W),
  .PTR_OFFSET (PTR_OFFSET)
) u_pag_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_legacy (req_legacy),
  .req_base   (req_base),
  .state      (state),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .done       (done),
  .allowed    (allowed)
);

// File: tb/port_access_gate_bench.sv
module port_access_gate_bench;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [PORT_W-1:0] req_port;
  logic [1:0]        req_width;
  logic              req_legacy;
  logic [ADDR_W-1:0] req_base;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready;
  logic [15:0]       mem_rdata;
  logic              done;
  logic              allowed;

  int          nchk  = 0;
  int          nfail = 0;
  int          cyc   = 0;
  int          wt    = 0;
  int          ridx  = 0;
  int          ready_cyc = 0;
  int          reqcyc = 0;
  logic [15:0] t_ptr, t_map;
  logic [31:0] addr0, addr1, hold_addr;
  bit          holding = 0;
  bit          hold_bad = 0;

  port_access_gate u_port_access_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_width(req_width), .req_legacy(req_legacy), .req_base(req_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .done(done), .allowed(allowed)
  );

  always #5 clk = ~clk;

  // Memory model: reacts 2 ns after each rising edge with a random wait.
  always begin
    @(posedge clk);
    #2;
    cyc++;
    if (mem_req) reqcyc++;
    if (mem_ready) begin
      mem_ready = 1'b0;
      wt = $urandom % 3;
    end else if (mem_req) begin
      if (holding && mem_addr != hold_addr) hold_bad = 1;
      if (!holding) begin holding = 1; hold_addr = mem_addr; end
      if (wt == 0) begin
        mem_ready = 1'b1;
        mem_rdata = (ridx == 0) ? t_ptr : t_map;
        if (ridx == 0) addr0 = mem_addr; else addr1 = mem_addr;
        ridx++;
        ready_cyc = cyc;
        holding = 0;
      end else begin
        wt--;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_ok(input logic [15:0] p, input logic [1:0] w,
                                input bit leg, input logic [15:0] mp);
    logic [15:0] m;
    if (leg) return 1'b0;
    m = (w == 2'd0) ? 16'h1 : (w == 2'd1) ? 16'h3 : 16'hF;
    m = m << p[2:0];
    return (mp & m) == 16'h0;
  endfunction

  task automatic run(input logic [15:0] p, input logic [1:0] w, input bit leg,
                     input logic [31:0] b, input logic [15:0] pt,
                     input logic [15:0] mp, input bit glitch);
    int  rc0;
    bit  got;
    @(negedge clk);
    t_ptr = pt; t_map = mp; ridx = 0; hold_bad = 0;
    rc0 = reqcyc;
    req_port = p; req_width = w; req_legacy = leg; req_base = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (leg) begin
      check(done === 1'b1, "R2", "legacy done", {31'd0, done}, 32'd1);
      check(allowed === 1'b0, "R2", "legacy allowed", {31'd0, allowed}, 32'd0);
      @(negedge clk);
      check(done === 1'b0, "R7", "done width", {31'd0, done}, 32'd0);
      check(reqcyc == rc0 && ridx == 0, "R2", "legacy mem reads",
            32'(reqcyc - rc0), 32'd0);
    end else begin
      if (glitch) begin
        req_valid = 1'b1; req_port = p ^ 16'h5A5A; req_legacy = 1'b1;
        req_base = b ^ 32'h0F0F_0F0F;
      end
      got = 0;
      for (int k = 0; k < 80 && !got; k++) begin
        if (k == 1) req_valid = 1'b0;
        if (done) got = 1;
        else @(negedge clk);
      end
      req_valid = 1'b0;
      check(got, "R7", "done seen", {31'd0, got}, 32'd1);
      check(cyc == ready_cyc + 1, "R7", "done timing", cyc, ready_cyc + 1);
      check(ridx == 2, glitch ? "R9" : "R4", "read count", ridx, 32'd2);
      check(addr0 == b + 32'd66, "R3", "pointer address", addr0, b + 32'd66);
      check(addr1 == {16'd0, pt} + {19'd0, p[15:3]}, "R4", "bitmap address",
            addr1, {16'd0, pt} + {19'd0, p[15:3]});
      check(allowed === exp_ok(p, w, 1'b0, mp), glitch ? "R9" : "R6",
            "allowed", {31'd0, allowed}, {31'd0, exp_ok(p, w, 1'b0, mp)});
      check(!hold_bad, "R8", "address held", {31'd0, hold_bad}, 32'd0);
      @(negedge clk);
      check(done === 1'b0, "R7", "done width", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_width = '0;
    req_legacy = 1'b0; req_base = '0; mem_ready = 1'b0; mem_rdata = '0;
    t_ptr = '0; t_map = '0; addr0 = '0; addr1 = '0; hold_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1", "reset done", {31'd0, done}, 32'd0);
    check(mem_req === 1'b0, "R1", "reset mem_req", {31'd0, mem_req}, 32'd0);

    // R2: older format refused without memory traffic
    run(16'h0040, 2'd0, 1'b1, 32'h0000_1000, 16'h0068, 16'h0000, 1'b0);
    // R5/R6: byte access, bit under mask set and clear
    run(16'h0005, 2'd0, 1'b0, 32'h0000_2000, 16'h0068, 16'h0020, 1'b0);
    run(16'h0005, 2'd0, 1'b0, 32'h0000_2000, 16'h0068, 16'hFFDF, 1'b0);
    // R5: doubleword at shift 7 reaches bit 10 of the second byte
    run(16'h0107, 2'd2, 1'b0, 32'h0000_3000, 16'h0100, 16'h0400, 1'b0);
    run(16'h0107, 2'd2, 1'b0, 32'h0000_3000, 16'h0100, 16'h0840, 1'b0);
    // R5: word at shift 7 covers bit 8
    run(16'h00FF, 2'd1, 1'b0, 32'h0000_4000, 16'h0200, 16'h0100, 1'b0);
    // R5: width code 3 behaves as doubleword
    run(16'h0003, 2'd3, 1'b0, 32'h0000_5000, 16'h0080, 16'h0040, 1'b0);
    run(16'h0003, 2'd3, 1'b0, 32'h0000_5000, 16'h0080, 16'hFF87, 1'b0);
    // R3: pointer address wraps at the address width
    run(16'hFFF8, 2'd0, 1'b0, 32'hFFFF_FFF0, 16'hFFFF, 16'h0000, 1'b0);
    // R9: request raised while busy is ignored
    run(16'h0012, 2'd1, 1'b0, 32'h0000_6000, 16'h0300, 16'h0008, 1'b1);
    run(16'h0012, 2'd1, 1'b0, 32'h0000_6000, 16'h0300, 16'h0010, 1'b1);

    for (int i = 0; i < 400; i++) begin
      run(16'($urandom), 2'($urandom), ($urandom % 8) == 0, $urandom,
          16'($urandom), 16'($urandom) & 16'($urandom), ($urandom % 4) == 0);
    end
    finish_run();
  end
endmodule